// File: doc/BRIEF.md
# Predicated Vector Element Sequencer

This block is the hardware loop behind a vector instruction. Once started, it steps an element index from a start position up to the vector length. Each cycle it offers one element to the execution unit: a source register number, a destination register number and an enable that says whether the element really executes. The block never reads the register file and never performs the operation. Its caller supplies the base register numbers, a scalar/vector flag for each operand, the predicate code and three mask words taken from the integer register file.

Two predication styles are available. In single mode, one mask governs each element in place, and an element whose predicate fails still takes its cycle with the enable low. In twin mode, the source side and the destination side each have their own mask and their own index. Masked-off elements are skipped on each side separately, and one move is issued for every matched source/destination pair. If the execution unit reports a trap on an executing element, the loop stops and the failing index is kept as the resume point. A run that completes normally clears the resume point to zero.

The masks are read live from the mask ports while a run is in progress and must stay stable until done. The length, start index, bases, flags and predicate code are captured at start.

Top module: `pred_elem_seq`

## Requirements
- R1: An operand whose effective flag is scalar (0) presents its base register number unchanged on every element of a run.
- R2: In single mode, elements are offered one per cycle with `issue_valid` high, in increasing index order from `vstart_in` to `vl-1`. The first element appears in the cycle after the start cycle. A vector operand's register number is its base plus the element index, modulo 128, and `elem_idx` carries that index.
- R3: Single-mode predicate code (3 bits). 000 means no predication. Code bits [2:1] pick the mask: 01 picks `mask_a`, 10 picks `mask_b`, 11 picks `mask_c`. Code bit 0 is the required mask-bit value. For each element, `elem_en` is 1 exactly when bit i of the picked mask equals that required value.
- R4: Twin-mode predicate code. Bit 0 set puts the source side under `mask_a`. Bit 1 set puts the destination side under `mask_b`. Bit 2 set means the governed sides need a 0 mask bit instead of a 1. Codes 000 and 100 leave both sides unpredicated.
- R5: In twin mode, the source and destination indices both begin at `vstart_in` and advance independently. A side whose current element is masked off steps past it. When both current elements are active, one move is issued with `issue_valid` and `elem_en` high, and both indices advance. The run ends as soon as either index reaches `vl`.
- R6: After normal completion, `done` is high for exactly one cycle, the cycle after the last element, and `vstart_out` reads 0.
- R7: A `trap` seen while `issue_valid` and `elem_en` are high ends the run. No further elements are issued, `done` pulses in the next cycle and `vstart_out` holds the trapping element's (source) index. Restarting with that index resumes at that element.
- R8: Single-mode code 001 is reserved. It sets `illegal`, issues no element, pulses `done` in the next cycle and leaves `vstart_out` equal to the given `vstart_in`.
- R9: If `vstart_in` is greater than or equal to `vl` at start, no element is issued, `done` pulses in the next cycle and `vstart_out` reads 0.
- R10: An operand whose flag is marked absent takes as its flag the OR of the flags that are marked present. If neither flag is present, both operands are scalar.
- R11: Out of reset, `issue_valid`, `done`, `illegal` and `vstart_out` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Begin a run (taken when idle) |
| twin_mode | input | 1 | 1 = twin predication, 0 = single |
| pred_code | input | 3 | Predicate code |
| vl | input | 7 | Vector length |
| vstart_in | input | 7 | Start / resume index |
| src_flag | input | 1 | Source operand is a vector |
| src_flag_present | input | 1 | Source flag is present |
| dst_flag | input | 1 | Destination operand is a vector |
| dst_flag_present | input | 1 | Destination flag is present |
| src_base | input | 7 | Source base register number |
| dst_base | input | 7 | Destination base register number |
| mask_a | input | 64 | First mask word |
| mask_b | input | 64 | Second mask word |
| mask_c | input | 64 | Third mask word |
| trap | input | 1 | Current element trapped |
| issue_valid | output | 1 | An element is offered this cycle |
| elem_en | output | 1 | Offered element executes |
| elem_idx | output | 7 | Source element index |
| src_reg | output | 7 | Source register number |
| dst_reg | output | 7 | Destination register number |
| vstart_out | output | 7 | Recorded resume index |
| done | output | 1 | One-cycle end-of-run pulse |
| illegal | output | 1 | Last start used a reserved code |

## Verification
The hardest situation to reach from the ports is a twin-mode run in which the source and destination indices drift apart. That happens only when the two masks disagree at several different positions, so that one side skips while the other waits. The twin tests use mask pairs with staggered holes and inverted senses, so the issued register pairs differ in offset from element to element. A trap landing in the middle of a run is the other hard case. The bench raises `trap` in the same cycle it sees a chosen element index offered, then restarts from the reported index and checks that the run picks up at exactly that element.

// File: rtl/pred_elem_seq_pkg.sv
package pred_elem_seq_pkg;
  typedef enum logic [1:0] {
    MSEL_NONE = 2'd0,
    MSEL_A    = 2'd1,
    MSEL_B    = 2'd2,
    MSEL_C    = 2'd3
  } msel_e;

  typedef struct packed {
    msel_e src_sel;
    logic  src_sense;
    msel_e dst_sel;
    logic  dst_sense;
    logic  bad;
  } pred_cfg_t;
endpackage

// File: rtl/pred_elem_seq_decode.sv
module pred_elem_seq_decode
  import pred_elem_seq_pkg::*;
(
  input  logic      twin,
  input  logic [2:0] code,
  output pred_cfg_t cfg
);
  always_comb begin
    cfg = '0;
    if (!twin) begin
      if (code == 3'b001) begin
        cfg.bad = 1'b1;
      end else if (code != 3'b000) begin
        cfg.src_sel   = msel_e'(code[2:1]);
        cfg.src_sense = code[0];
        cfg.dst_sel   = msel_e'(code[2:1]);
        cfg.dst_sense = code[0];
      end
    end else begin
      cfg.src_sel   = code[0] ? MSEL_A : MSEL_NONE;
      cfg.dst_sel   = code[1] ? MSEL_B : MSEL_NONE;
      cfg.src_sense = ~code[2];
      cfg.dst_sense = ~code[2];
    end
  end
endmodule

// File: rtl/pred_elem_seq_mask.sv
module pred_elem_seq_mask
  import pred_elem_seq_pkg::*;
#(
  parameter int MAXVL = 64,
  parameter int IDX_W = $clog2(MAXVL + 1)
) (
  input  msel_e              sel,
  input  logic               sense,
  input  logic [MAXVL-1:0]   mask_a,
  input  logic [MAXVL-1:0]   mask_b,
  input  logic [MAXVL-1:0]   mask_c,
  input  logic [IDX_W-1:0]   idx,
  output logic               active
);
  localparam int SEL_W = (MAXVL > 1) ? $clog2(MAXVL) : 1;

  logic [MAXVL-1:0] word;
  logic             in_range;

  always_comb begin
    case (sel)
      MSEL_A:  word = mask_a;
      MSEL_B:  word = mask_b;
      MSEL_C:  word = mask_c;
      default: word = '0;
    endcase
    in_range = (idx < IDX_W'(MAXVL));
    if (sel == MSEL_NONE) active = 1'b1;
    else if (!in_range)   active = 1'b0;
    else                  active = (word[idx[SEL_W-1:0]] == sense);
  end
endmodule

// File: rtl/pred_elem_seq_regnum.sv
module pred_elem_seq_regnum #(
  parameter int REG_W = 7,
  parameter int IDX_W = 7
) (
  input  logic             is_vec,
  input  logic [REG_W-1:0] base,
  input  logic [IDX_W-1:0] idx,
  output logic [REG_W-1:0] reg_num
);
  logic [REG_W-1:0] offset;

  always_comb begin
    offset  = REG_W'(idx);
    reg_num = is_vec ? (base + offset) : base;
  end
endmodule

// File: rtl/pred_elem_seq.sv
module pred_elem_seq
  import pred_elem_seq_pkg::*;
#(
  parameter int MAXVL = 64,
  parameter int REG_W = 7,
  parameter int IDX_W = $clog2(MAXVL + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic             twin_mode,
  input  logic [2:0]       pred_code,
  input  logic [IDX_W-1:0] vl,
  input  logic [IDX_W-1:0] vstart_in,
  input  logic             src_flag,
  input  logic             src_flag_present,
  input  logic             dst_flag,
  input  logic             dst_flag_present,
  input  logic [REG_W-1:0] src_base,
  input  logic [REG_W-1:0] dst_base,
  input  logic [MAXVL-1:0] mask_a,
  input  logic [MAXVL-1:0] mask_b,
  input  logic [MAXVL-1:0] mask_c,
  input  logic             trap,
  output logic             issue_valid,
  output logic             elem_en,
  output logic [IDX_W-1:0] elem_idx,
  output logic [REG_W-1:0] src_reg,
  output logic [REG_W-1:0] dst_reg,
  output logic [IDX_W-1:0] vstart_out,
  output logic             done,
  output logic             illegal
);
  localparam logic [IDX_W-1:0] ONE = IDX_W'(1);

  pred_cfg_t        cfg_in, cfg_q, cfg_n;
  logic             busy_q, busy_n, done_q, done_n, ill_q, ill_n;
  logic             twin_q, twin_n, svec_q, svec_n, dvec_q, dvec_n;
  logic [REG_W-1:0] sbase_q, sbase_n, dbase_q, dbase_n;
  logic [IDX_W-1:0] vl_q, vl_n, sidx_q, sidx_n, didx_q, didx_n, vst_q, vst_n;
  logic             s_act, d_act, s_adv, d_adv, trap_take, finish, accept;
  logic             flag_or, svec_eff, dvec_eff;
  logic [IDX_W-1:0] s_step, d_step;

  pred_elem_seq_decode u_dec (.twin(twin_mode), .code(pred_code), .cfg(cfg_in));

  // one mask lookup per side
  pred_elem_seq_mask #(.MAXVL(MAXVL), .IDX_W(IDX_W)) u_smask (
    .sel(cfg_q.src_sel), .sense(cfg_q.src_sense), .mask_a(mask_a),
    .mask_b(mask_b), .mask_c(mask_c), .idx(sidx_q), .active(s_act));
  pred_elem_seq_mask #(.MAXVL(MAXVL), .IDX_W(IDX_W)) u_dmask (
    .sel(cfg_q.dst_sel), .sense(cfg_q.dst_sense), .mask_a(mask_a),
    .mask_b(mask_b), .mask_c(mask_c), .idx(didx_q), .active(d_act));

  pred_elem_seq_regnum #(.REG_W(REG_W), .IDX_W(IDX_W)) u_sreg (
    .is_vec(svec_q), .base(sbase_q), .idx(sidx_q), .reg_num(src_reg));
  pred_elem_seq_regnum #(.REG_W(REG_W), .IDX_W(IDX_W)) u_dreg (
    .is_vec(dvec_q), .base(dbase_q), .idx(didx_q), .reg_num(dst_reg));

  always_comb begin
    flag_or  = (src_flag_present & src_flag) | (dst_flag_present & dst_flag);
    svec_eff = src_flag_present ? src_flag : flag_or;
    dvec_eff = dst_flag_present ? dst_flag : flag_or;

    if (twin_q) begin
      issue_valid = busy_q & s_act & d_act;
      elem_en     = issue_valid;
      s_adv       = ~s_act | d_act;
      d_adv       = ~d_act | s_act;
    end else begin
      issue_valid = busy_q;
      elem_en     = busy_q & s_act;
      s_adv       = 1'b1;
      d_adv       = 1'b1;
    end
    s_step    = s_adv ? sidx_q + ONE : sidx_q;
    d_step    = d_adv ? didx_q + ONE : didx_q;
    trap_take = issue_valid & elem_en & trap;
    finish    = busy_q & ((s_step >= vl_q) | (d_step >= vl_q));
    accept    = start & ~busy_q;
  end

  always_comb begin
    busy_n  = busy_q;
    done_n  = 1'b0;
    ill_n   = ill_q;
    cfg_n   = cfg_q;
    twin_n  = twin_q;
    svec_n  = svec_q;
    dvec_n  = dvec_q;
    sbase_n = sbase_q;
    dbase_n = dbase_q;
    vl_n    = vl_q;
    sidx_n  = sidx_q;
    didx_n  = didx_q;
    vst_n   = vst_q;
    if (accept) begin
      cfg_n   = cfg_in;
      twin_n  = twin_mode;
      svec_n  = svec_eff;
      dvec_n  = dvec_eff;
      sbase_n = src_base;
      dbase_n = dst_base;
      vl_n    = vl;
      sidx_n  = vstart_in;
      didx_n  = vstart_in;
      ill_n   = cfg_in.bad;
      if (cfg_in.bad) begin
        done_n = 1'b1;
        vst_n  = vstart_in;
      end else if (vstart_in >= vl) begin
        done_n = 1'b1;
        vst_n  = '0;
      end else begin
        busy_n = 1'b1;
        vst_n  = vstart_in;
      end
    end else if (busy_q) begin
      if (trap_take) begin
        busy_n = 1'b0;
        done_n = 1'b1;
        vst_n  = sidx_q;
      end else if (finish) begin
        busy_n = 1'b0;
        done_n = 1'b1;
        vst_n  = '0;
      end else begin
        sidx_n = s_step;
        didx_n = d_step;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q  <= 1'b0;
      done_q  <= 1'b0;
      ill_q   <= 1'b0;
      cfg_q   <= '0;
      twin_q  <= 1'b0;
      svec_q  <= 1'b0;
      dvec_q  <= 1'b0;
      sbase_q <= '0;
      dbase_q <= '0;
      vl_q    <= '0;
      sidx_q  <= '0;
      didx_q  <= '0;
      vst_q   <= '0;
    end else begin
      busy_q  <= busy_n;
      done_q  <= done_n;
      ill_q   <= ill_n;
      cfg_q   <= cfg_n;
      twin_q  <= twin_n;
      svec_q  <= svec_n;
      dvec_q  <= dvec_n;
      sbase_q <= sbase_n;
      dbase_q <= dbase_n;
      vl_q    <= vl_n;
      sidx_q  <= sidx_n;
      didx_q  <= didx_n;
      vst_q   <= vst_n;
    end
  end

  assign elem_idx   = sidx_q;
  assign vstart_out = vst_q;
  assign done       = done_q;
  assign illegal    = ill_q;

  // R1
  scalar_src_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_q && $past(busy_q) && !svec_q) |-> $stable(src_reg));

  // R2
  vec_src_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_q && $past(busy_q) && !twin_q && svec_q) |->
      (src_reg == $past(src_reg) + REG_W'(1)));

  // R5
  twin_pair_en_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_q && twin_q) |-> (issue_valid == elem_en));

  // R8
  illegal_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    illegal |-> !issue_valid);

  // R9
  empty_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && !cfg_in.bad && (vstart_in >= vl)) |=> (done && !issue_valid));

  // R6
  finish_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_q && finish && !trap_take) |=> (done && vstart_out == '0));
endmodule

// File: tb/pred_elem_seq_bench.sv
`timescale 1ns/1ps
module pred_elem_seq_bench;
  localparam int MAXVL = 64;
  localparam int RW = 7;
  localparam int IW = 7;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start = 1'b0, twin_mode = 1'b0, trap = 1'b0;
  logic [2:0] pred_code = '0;
  logic [IW-1:0] vl = '0, vstart_in = '0;
  logic src_flag = 0, src_flag_present = 0, dst_flag = 0, dst_flag_present = 0;
  logic [RW-1:0] src_base = '0, dst_base = '0;
  logic [MAXVL-1:0] mask_a = '0, mask_b = '0, mask_c = '0;
  logic issue_valid, elem_en, done, illegal;
  logic [IW-1:0] elem_idx, vstart_out;
  logic [RW-1:0] src_reg, dst_reg;

  int n_chk = 0, n_bad = 0;
  int got_n, exp_n;
  int got_s[0:127], got_d[0:127], exp_s[0:127], exp_d[0:127];
  bit got_e[0:127], exp_e[0:127];
  int exp_vs;
  bit exp_ill;

  always #2 clk = ~clk;

  pred_elem_seq u_pred_elem_seq (
    .clk(clk), .rst_n(rst_n), .start(start), .twin_mode(twin_mode),
    .pred_code(pred_code), .vl(vl), .vstart_in(vstart_in),
    .src_flag(src_flag), .src_flag_present(src_flag_present),
    .dst_flag(dst_flag), .dst_flag_present(dst_flag_present),
    .src_base(src_base), .dst_base(dst_base), .mask_a(mask_a),
    .mask_b(mask_b), .mask_c(mask_c), .trap(trap),
    .issue_valid(issue_valid), .elem_en(elem_en), .elem_idx(elem_idx),
    .src_reg(src_reg), .dst_reg(dst_reg), .vstart_out(vstart_out),
    .done(done), .illegal(illegal));

  task automatic check(string req, string what, longint act, longint exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  function automatic bit mbit(int sel, bit sense, int i);
    logic [MAXVL-1:0] w;
    if (sel == 0) return 1'b1;
    w = (sel == 1) ? mask_a : (sel == 2) ? mask_b : mask_c;
    return (w[i] == sense);
  endfunction

  // Reference model written from the requirement text
  task automatic model(bit tw, logic [2:0] code, int vl_i, int vs_i,
                       bit sv, bit dv, int trap_i);
    int ssel = 0, dsel = 0, s, d;
    bit ss = 1, ds = 1, bad = 0, sa, da;
    if (!tw) begin
      if (code == 3'b001) bad = 1;
      else if (code != 0) begin
        ssel = int'(code[2:1]); ss = code[0]; dsel = ssel; ds = ss;
      end
    end else begin
      ssel = code[0] ? 1 : 0; dsel = code[1] ? 2 : 0;
      ss = !code[2]; ds = ss;
    end
    exp_n = 0; exp_ill = bad; exp_vs = 0;
    if (bad) begin exp_vs = vs_i; return; end
    s = vs_i; d = vs_i;
    while (s < vl_i && d < vl_i) begin
      sa = mbit(ssel, ss, s); da = mbit(dsel, ds, d);
      if (!tw) begin
        exp_s[exp_n] = sv ? ((int'(src_base) + s) % 128) : int'(src_base);
        exp_d[exp_n] = dv ? ((int'(dst_base) + s) % 128) : int'(dst_base);
        exp_e[exp_n] = sa; exp_n++;
        if (sa && s == trap_i) begin exp_vs = s; break; end
        s++; d++;
      end else if (sa && da) begin
        exp_s[exp_n] = sv ? ((int'(src_base) + s) % 128) : int'(src_base);
        exp_d[exp_n] = dv ? ((int'(dst_base) + d) % 128) : int'(dst_base);
        exp_e[exp_n] = 1; exp_n++;
        s++; d++;
      end else begin
        if (!sa) s++;
        if (!da) d++;
      end
    end
  endtask

  task automatic run(string req, bit tw, logic [2:0] code, int vl_i, int vs_i,
                     bit sv, bit svp, bit dv, bit dvp, bit sv_eff, bit dv_eff,
                     int trap_i);
    bit seen_done = 0;
    model(tw, code, vl_i, vs_i, sv_eff, dv_eff, trap_i);
    @(negedge clk);
    twin_mode = tw; pred_code = code; vl = IW'(vl_i); vstart_in = IW'(vs_i);
    src_flag = sv; src_flag_present = svp; dst_flag = dv; dst_flag_present = dvp;
    start = 1;
    @(negedge clk);
    start = 0; got_n = 0;
    for (int c = 0; c < 300; c++) begin
      trap = 0;
      if (done) begin seen_done = 1; break; end
      if (issue_valid && got_n < 128) begin
        got_s[got_n] = int'(src_reg); got_d[got_n] = int'(dst_reg);
        got_e[got_n] = elem_en; got_n++;
        if (elem_en && int'(elem_idx) == trap_i) trap = 1;
      end
      @(negedge clk);
    end
    trap = 0;
    check(req, "done seen", seen_done, 1);
    check(req, "element count", got_n, exp_n);
    for (int k = 0; k < exp_n && k < got_n; k++) begin
      check(req, $sformatf("src_reg[%0d]", k), got_s[k], exp_s[k]);
      check(req, $sformatf("dst_reg[%0d]", k), got_d[k], exp_d[k]);
      check(req, $sformatf("elem_en[%0d]", k), got_e[k], exp_e[k]);
    end
    check(req, "vstart_out", vstart_out, exp_vs);
    check(req, "illegal", illegal, exp_ill);
    @(negedge clk);
    check(req, "done one cycle", done, 0);
  endtask

  task automatic t_reset;
    @(negedge clk);
    check("R11", "issue_valid", issue_valid, 0);
    check("R11", "done", done, 0);
    check("R11", "illegal", illegal, 0);
    check("R11", "vstart_out", vstart_out, 0);
  endtask

  task automatic t_vector_plain;  // R2 R6
    src_base = 7'd10; dst_base = 7'd124;
    run("R2", 0, 3'b000, 6, 0, 1, 1, 1, 1, 1, 1, -1);
    run("R6", 0, 3'b000, 9, 3, 1, 1, 1, 1, 1, 1, -1);
  endtask

  task automatic t_scalar;  // R1
    src_base = 7'd5; dst_base = 7'd40;
    run("R1", 0, 3'b000, 5, 0, 0, 1, 1, 1, 0, 1, -1);
    run("R1", 0, 3'b000, 4, 1, 1, 1, 0, 1, 1, 0, -1);
  endtask

  task automatic t_single_pred;  // R3
    mask_a = 64'h0000_0000_0000_00A5;
    mask_b = 64'h0000_0000_0000_000F;
    mask_c = 64'h8000_0000_0000_0033;
    src_base = 7'd20; dst_base = 7'd60;
    run("R3", 0, 3'b011, 8, 0, 1, 1, 1, 1, 1, 1, -1);
    run("R3", 0, 3'b010, 8, 0, 1, 1, 1, 1, 1, 1, -1);
    run("R3", 0, 3'b100, 6, 1, 1, 1, 1, 1, 1, 1, -1);
    run("R3", 0, 3'b111, 64, 58, 1, 1, 0, 1, 1, 0, -1);
    run("R3", 0, 3'b110, 7, 0, 1, 1, 1, 1, 1, 1, -1);
  endtask

  task automatic t_twin;  // R4 R5
    mask_a = 64'h0000_0000_0000_00B6;
    mask_b = 64'h0000_0000_0000_00D5;
    src_base = 7'd0; dst_base = 7'd100;
    run("R5", 1, 3'b011, 8, 0, 1, 1, 1, 1, 1, 1, -1);
    run("R4", 1, 3'b001, 8, 0, 1, 1, 1, 1, 1, 1, -1);
    run("R4", 1, 3'b010, 8, 0, 1, 1, 1, 1, 1, 1, -1);
    run("R4", 1, 3'b101, 8, 0, 1, 1, 1, 1, 1, 1, -1);
    run("R4", 1, 3'b110, 8, 1, 1, 1, 1, 1, 1, 1, -1);
    run("R5", 1, 3'b111, 10, 0, 1, 1, 1, 1, 1, 1, -1);
    run("R4", 1, 3'b100, 5, 0, 1, 1, 1, 1, 1, 1, -1);
    run("R4", 1, 3'b000, 4, 2, 1, 1, 0, 1, 1, 0, -1);
  endtask

  task automatic t_trap;  // R7
    mask_a = 64'h0000_0000_0000_03EF;
    src_base = 7'd30; dst_base = 7'd70;
    run("R7", 0, 3'b000, 10, 0, 1, 1, 1, 1, 1, 1, 4);
    run("R7", 0, 3'b000, 10, 4, 1, 1, 1, 1, 1, 1, -1);
    run("R7", 0, 3'b011, 10, 2, 1, 1, 1, 1, 1, 1, 7);
  endtask

  task automatic t_illegal;  // R8
    run("R8", 0, 3'b001, 8, 3, 1, 1, 1, 1, 1, 1, -1);
    run("R8", 0, 3'b000, 2, 0, 1, 1, 1, 1, 1, 1, -1);
  endtask

  task automatic t_empty;  // R9
    run("R9", 0, 3'b000, 4, 4, 1, 1, 1, 1, 1, 1, -1);
    run("R9", 1, 3'b011, 3, 9, 1, 1, 1, 1, 1, 1, -1);
    run("R9", 0, 3'b000, 0, 0, 1, 1, 1, 1, 1, 1, -1);
  endtask

  task automatic t_absent;  // R10
    src_base = 7'd12; dst_base = 7'd90;
    run("R10", 0, 3'b000, 4, 0, 0, 0, 1, 1, 1, 1, -1);
    run("R10", 0, 3'b000, 4, 0, 0, 1, 1, 0, 0, 0, -1);
    run("R10", 0, 3'b000, 4, 0, 1, 0, 1, 0, 0, 0, -1);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    t_reset();
    t_vector_plain();
    t_scalar();
    t_single_pred();
    t_twin();
    t_trap();
    t_illegal();
    t_empty();
    t_absent();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    #400000;
    n_chk++; n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule